// File: doc/BRIEF.md
# Power-Mode-Aware Watchdog Timer

This block is the watchdog of a small microcontroller-style core. Once software arms it with a service strobe, it counts clock cycles. If software does not service it in time, the counter wraps past its all-ones value and the block raises a device reset request for a fixed number of cycles. Nothing but a hardware reset can disarm it.

Counting follows the core's low-power state:

- **Power-down:** the count is frozen, since the oscillator is stopped.
- **Idle:** a control bit decides whether counting continues or holds its value until idle ends.
- **Wake-up by interrupt:** when the core leaves power-down because a level-sensitive interrupt line was held low, the count stays held until that line returns high. This keeps the watchdog from firing while the line is held low.
- **Wake-up by hardware reset:** leaving power-down this way gives the ordinary reset state.

Top module: `pm_watchdog`

## Requirements
- R1: After hardware reset the watchdog is disarmed. `count_o` reads 0 and `wdt_rst_o` is 0, and the count stays 0 until the first service strobe.
- R2: A high `kick_i` at a clock edge arms the watchdog and makes `count_o` 0 after that edge. While armed and not gated, `count_o` rises by exactly 1 per clock edge.
- R3: Once armed, the watchdog stays armed through power-down, idle and wake-up. Only `rst_n` low disarms it.
- R4: While `pd_i` is 1 the count does not change, except for a clear by `kick_i`.
- R5: While `idle_i` is 1 and `idle_frz_i` is 0 the count keeps advancing. While `idle_i` and `idle_frz_i` are both 1 it holds its value, and it resumes from that value once either input drops.
- R6: If `wake_n_i` is 0 in the first cycle after `pd_i` falls, the count holds for as long as `wake_n_i` stays 0. It advances again at the first edge at which `wake_n_i` is 1.
- R7: `wake_n_i` low has no effect on counting outside the power-down exit window of R6.
- R8: Counting from all-ones makes `count_o` 0 and raises `wdt_rst_o` at the same edge. `wdt_rst_o` stays 1 for exactly `RST_PULSE` cycles.
- R9: If `kick_i` is 1 at the edge where the count would wrap, the clear wins: `count_o` becomes 0 and `wdt_rst_o` stays 0.
- R10: A hardware reset taken during power-down, with `wake_n_i` low, gives the R1 state with no wake hold. After a new strobe the count advances even while `wake_n_i` is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| pd_i | input | 1 | Core is in power-down |
| idle_i | input | 1 | Core is in idle |
| idle_frz_i | input | 1 | 1: freeze the count during idle; 0: keep counting |
| wake_n_i | input | 1 | Level of the wake interrupt pin, active low |
| kick_i | input | 1 | Service strobe: clears the count and arms the watchdog |
| wdt_rst_o | output | 1 | Device reset request |
| count_o | output | CNT_W | Current count value |

## Verification
Every input acts at the next rising edge, so `count_o` shows the effect of a stimulus one edge after it is applied. `wdt_rst_o` rises at the very edge where `count_o` wraps to 0 and falls `RST_PULSE` edges later. The wake hold of R6 takes effect at the first edge after `pd_i` falls, and it releases at the first edge that sees `wake_n_i` high. The bench drives inputs on the falling edge and compares on the following falling edge against a cycle model. This lands each comparison exactly one rising edge after the stimulus. Directed runs cover the full wrap, the pulse length, and a strobe that coincides with the wrap.

// File: rtl/pm_watchdog.sv
module pm_watchdog #(
  parameter int CNT_W     = 14,
  parameter int RST_PULSE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_i,
  input  logic             idle_i,
  input  logic             idle_frz_i,
  input  logic             wake_n_i,
  input  logic             kick_i,
  output logic             wdt_rst_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PW = $clog2(RST_PULSE + 1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [PW-1:0] PULSE_LEN = PW'(RST_PULSE);

  logic          en, hold, pd_q;
  logic [PW-1:0] pulse;
  logic          stall, run, wrap;

  assign stall = (hold | pd_q) & ~wake_n_i;
  assign run   = en & ~pd_i & ~(idle_i & idle_frz_i) & ~stall;
  assign wrap  = run & (count_o == TOP) & ~kick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      hold    <= 1'b0;
      pd_q    <= 1'b0;
      count_o <= '0;
    end else begin
      pd_q <= pd_i;
      hold <= stall;
      if (kick_i) begin
        en      <= 1'b1;
        count_o <= '0;
      end else if (run) begin
        count_o <= count_o + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse <= '0;
    else if (wrap)           pulse <= PULSE_LEN;
    else if (pulse != '0)    pulse <= pulse - 1'b1;
  end

  assign wdt_rst_o = (pulse != '0);
endmodule

// File: rtl/pm_watchdog_chk.sv
module pm_watchdog_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_i,
  input logic             idle_i,
  input logic             idle_frz_i,
  input logic             wake_n_i,
  input logic             kick_i,
  input logic             en,
  input logic             hold,
  input logic             wdt_rst_o,
  input logic [CNT_W-1:0] count_o
);
  a_r1_zero_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> count_o == '0);
  a_r2_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> count_o == '0);
  a_r3_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  a_r4_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_i && !kick_i) |=> $stable(count_o));
  a_r5_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && idle_frz_i && !kick_i) |=> $stable(count_o));
  a_r6_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wake_n_i && !kick_i) |=> $stable(count_o));
  a_r8_pulse_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> count_o == '0);
endmodule

bind pm_watchdog pm_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .idle_i(idle_i),
  .idle_frz_i(idle_frz_i), .wake_n_i(wake_n_i), .kick_i(kick_i),
  .en(en), .hold(hold), .wdt_rst_o(wdt_rst_o), .count_o(count_o)
);

// File: tb/pm_watchdog_test.sv
module pm_watchdog_test;
  localparam int CNT_W = 14;
  localparam int RST_PULSE = 4;
  localparam int TOPV = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, pd = 0, idle = 0, frz = 0, wake_n = 1, kick = 0;
  logic wdt_rst;
  logic [CNT_W-1:0] count;
  int total = 0, bad = 0;
  bit done = 0;

  int m_cnt, m_pulse;
  bit m_en, m_hold, m_pdq;

  always #2.5 clk = ~clk;

  pm_watchdog #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .idle_i(idle), .idle_frz_i(frz),
    .wake_n_i(wake_n), .kick_i(kick), .wdt_rst_o(wdt_rst), .count_o(count)
  );

  function automatic bit gated(bit en, bit pdv, bit idl, bit fz, bit stall);
    return !en || pdv || (idl && fz) || stall;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_cnt = 0; m_hold = 0; m_pdq = 0; m_pulse = 0;
    end else begin
      bit st;
      st = (m_hold || m_pdq) && !wake_n;
      if (m_pulse > 0) m_pulse--;
      if (kick) begin
        m_en = 1; m_cnt = 0;
      end else if (!gated(m_en, pd, idle, frz, st)) begin
        if (m_cnt == TOPV) begin m_cnt = 0; m_pulse = RST_PULSE; end
        else m_cnt++;
      end
      m_hold = st; m_pdq = pd;
    end
  end

  task automatic chk(string tag);
    total++;
    if (count !== CNT_W'(m_cnt) || wdt_rst !== (m_pulse != 0)) begin
      bad++;
      $display("FAIL %s: count=%0d rst=%0b expected count=%0d rst=%0b",
               tag, count, wdt_rst, m_cnt, m_pulse != 0);
    end
  endtask

  task automatic chk_lit(string tag, int c, bit r);
    total++;
    if (count !== CNT_W'(c) || wdt_rst !== r) begin
      bad++;
      $display("FAIL %s: count=%0d rst=%0b expected count=%0d rst=%0b",
               tag, count, wdt_rst, c, r);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_up();
  end

  initial begin
    int hold_val;
    cyc(3); rst_n = 1; cyc(5);
    chk_lit("R1 reset state, no counting before kick", 0, 0);

    kick = 1; cyc(1); kick = 0;
    chk_lit("R2 kick clears", 0, 0);
    cyc(10); chk_lit("R2 one per cycle", 10, 0);

    pd = 1; cyc(20); chk_lit("R4 frozen in power-down", 10, 0);

    wake_n = 0; cyc(2); pd = 0; cyc(15);
    chk_lit("R6 held while wake pin low", 10, 0);
    wake_n = 1; cyc(1); chk_lit("R6 resumes on release", 11, 0);
    cyc(4); chk("R6");

    wake_n = 0; cyc(5); wake_n = 1; chk_lit("R7 wake low ignored in run", 20, 0);

    idle = 1; frz = 0; cyc(8); chk_lit("R5 idle counts", 28, 0);
    frz = 1; cyc(8); chk_lit("R5 idle frozen", 28, 0);
    idle = 0; cyc(2); chk_lit("R5 resumes after idle", 30, 0);
    frz = 0;

    pd = 1; cyc(6); pd = 0; cyc(3); chk_lit("R3 armed after power-down", 33, 0);

    kick = 1; cyc(1); kick = 0;
    cyc(TOPV); chk_lit("R8 at all-ones", TOPV, 0);
    cyc(1); chk_lit("R8 wrap raises request", 1 - 1, 1);
    for (int i = 1; i < RST_PULSE; i++) begin cyc(1); chk("R8 pulse held"); end
    cyc(1); chk_lit("R8 pulse ends", RST_PULSE, 0);

    kick = 1; cyc(1); kick = 0;
    cyc(TOPV); chk_lit("R9 at all-ones", TOPV, 0);
    kick = 1; cyc(1); kick = 0; chk_lit("R9 clear wins over wrap", 0, 0);
    cyc(3); chk_lit("R9 no request", 3, 0);

    pd = 1; wake_n = 0; cyc(3); rst_n = 0; cyc(2); rst_n = 1; pd = 0; cyc(5);
    chk_lit("R10 reset from power-down", 0, 0);
    kick = 1; cyc(1); kick = 0; cyc(4);
    chk_lit("R10 no wake hold after reset", 4, 0);
    wake_n = 1;

    for (int i = 0; i < 4000; i++) begin
      pd     = ($urandom % 8) == 0;
      idle   = ($urandom % 4) == 0;
      frz    = $urandom % 2;
      wake_n = ($urandom % 3) != 0;
      kick   = ($urandom % 50) == 0;
      rst_n  = ($urandom % 500) != 0;
      cyc(1);
      chk("R6 random mix");
    end
    rst_n = 1; kick = 0; pd = 0;
    finish_up();
  end

  initial void'($urandom(32'h5eed_0042));
endmodule